// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a timer. It watches a counter value shared by the rest of the timer and works in one of two ways: as an output-compare unit that drives a pin when the counter reaches a programmed value, or as an input-capture unit that stores the counter value when a chosen edge arrives on an input pin. A 5-bit control word selects the function and the interrupt enable. A channel value register holds the match value in compare modes and the captured count in capture modes. A sticky event flag is set by every match or capture and is cleared by writing a 1.

A new control word does not take effect at once. It becomes active a fixed number of clocks after the write, and only then is it returned on the control read-back port. Software treats a mode change, including a disable, as complete once the read-back equals the written word. The counter advances on clocks where `cnt_tick` is high. A match is evaluated only on those clocks, so a pulse output lasts one counter period.

Top module: `ccc_channel`

## Requirements
- R1: After a synchronous reset, `cmp_pin`, `flag`, `irq`, `ctrl_rd` and `value_rd` are all 0.
- R2: A control write (address 0) stores wr_data[4:0]: bits [1:0] are the level/edge select, bits [3:2] the mode and bit 4 the interrupt enable. `ctrl_rd` keeps its old value for ACK_LAT clocks after the write edge and shows the new word from the ACK_LAT-th edge after it. The new function applies from that same point.
- R3: In mode 01 or 11, a match is a clock where `cnt_tick` is 1 and `cnt_val` equals the value register. A match sets `flag` at the next edge. An equal count with `cnt_tick` at 0 is not a match.
- R4: In mode 01, a match leaves `cmp_pin` unchanged when the select is 00, toggles it for 01, clears it for 10 and sets it for 11.
- R5: In mode 11, select 01 gives a high pulse and 10 gives a low pulse. When such a mode becomes active, the pin goes to its idle level (low for 01, high for 10). A match drives the pin to its active level until the next `cnt_tick` edge, which is exactly one counter period.
- R6: In mode 00, select 01 captures on rising edges of `cap_pin`, 10 on falling edges and 11 on both. The pin passes through SYNC_STAGES flops. The value register and `flag` update on the (SYNC_STAGES+1)-th clock edge after the pin changes, and the register takes the `cnt_val` present just before that edge.
- R7: A capture while `flag` is still set overwrites the value register with the newer count. Value writes (address 1) are ignored while a capture mode is active.
- R8: Writing wr_data[0]=1 to address 2 clears `flag`, and writing 0 there has no effect. When a match or capture falls in the same clock, the set wins. `irq` is high exactly when `flag` is set and the active interrupt enable is 1.
- R9: Mode 00 with select 00, mode 10, and mode 11 with select 00 or 11 disable the channel. There is no match and no capture, the flag is not set, and `cmp_pin` is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CW | Shared counter value |
| cnt_tick | input | 1 | Counter advances at this clock's edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 value, 2 flag clear |
| wr_data | input | CW | Write data |
| cap_pin | input | 1 | Asynchronous capture input |
| cmp_pin | output | 1 | Compare output pin |
| ctrl_rd | output | 5 | Active control word (read-back acknowledge) |
| value_rd | output | CW | Channel value register |
| flag | output | 1 | Channel event flag |
| irq | output | 1 | Interrupt request |

## Verification
A stale active control word shows up as a read-back that changes one clock too early or too late, or as a compare or capture behaviour that belongs to the previous mode. Either is visible within ACK_LAT+1 clocks of the write. A wrong pin register or pulse state shows on `cmp_pin` at the first `cnt_tick` after the match. A broken synchronizer or edge detector shows as a value register that updates on the wrong clock edge or holds the wrong count. Each of these is observable no later than SYNC_STAGES+1 clocks after the pin transition.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  localparam int CTRL_W  = 5;
  localparam int SEL_LSB = 0;
  localparam int MODE_LSB = 2;
  localparam int IEN_BIT = 4;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_VAL  = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  typedef enum logic [3:0] {
    FN_OFF,
    FN_CMP_ONLY,
    FN_TOGGLE,
    FN_CLEAR,
    FN_SET,
    FN_PULSE_HI,
    FN_PULSE_LO,
    FN_CAP_RISE,
    FN_CAP_FALL,
    FN_CAP_BOTH
  } ccc_fn_e;

  function automatic ccc_fn_e ccc_decode(input logic [1:0] mode, input logic [1:0] sel);
    ccc_fn_e f;
    f = FN_OFF;
    case (mode)
      2'b00: begin
        case (sel)
          2'b01:   f = FN_CAP_RISE;
          2'b10:   f = FN_CAP_FALL;
          2'b11:   f = FN_CAP_BOTH;
          default: f = FN_OFF;
        endcase
      end
      2'b01: begin
        case (sel)
          2'b00:   f = FN_CMP_ONLY;
          2'b01:   f = FN_TOGGLE;
          2'b10:   f = FN_CLEAR;
          default: f = FN_SET;
        endcase
      end
      2'b11: begin
        case (sel)
          2'b01:   f = FN_PULSE_HI;
          2'b10:   f = FN_PULSE_LO;
          default: f = FN_OFF;
        endcase
      end
      default: f = FN_OFF;
    endcase
    return f;
  endfunction

  function automatic logic ccc_is_compare(input ccc_fn_e f);
    return (f == FN_CMP_ONLY) || (f == FN_TOGGLE) || (f == FN_CLEAR) ||
           (f == FN_SET) || (f == FN_PULSE_HI) || (f == FN_PULSE_LO);
  endfunction

  function automatic logic ccc_is_capture(input ccc_fn_e f);
    return (f == FN_CAP_RISE) || (f == FN_CAP_FALL) || (f == FN_CAP_BOTH);
  endfunction
endpackage

// File: rtl/ccc_mode_ctl.sv
module ccc_mode_ctl
  import ccc_pkg::*;
#(
  parameter int ACK_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wr_word,
  output logic [CTRL_W-1:0] ctrl_act,
  output ccc_fn_e           fn,
  output logic              ien,
  output logic              apply
);
  localparam int LW = $clog2(ACK_LAT + 1) + 1;

  logic [CTRL_W-1:0] req_q;
  logic [CTRL_W-1:0] act_q;
  logic [LW-1:0]     wait_q;
  logic              apply_q;

  // Requested word waits ACK_LAT clocks before it becomes the active one.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= '0;
      act_q   <= '0;
      wait_q  <= '0;
      apply_q <= 1'b0;
    end else begin
      apply_q <= 1'b0;
      if (wr_ctrl) begin
        req_q  <= wr_word;
        wait_q <= LW'(ACK_LAT);
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
        if (wait_q == LW'(1)) begin
          act_q   <= req_q;
          apply_q <= 1'b1;
        end
      end
    end
  end

  assign ctrl_act = act_q;
  assign fn       = ccc_decode(act_q[MODE_LSB +: 2], act_q[SEL_LSB +: 2]);
  assign ien      = act_q[IEN_BIT];
  assign apply    = apply_q;
endmodule

// File: rtl/ccc_capture.sv
module ccc_capture
  import ccc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pin_in,
  input  ccc_fn_e fn,
  output logic    cap_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   now_lvl;
  logic                   rise;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign now_lvl = sync_q[SYNC_STAGES-1];
  assign rise    = now_lvl & ~prev_q;
  assign fall    = ~now_lvl & prev_q;

  always_comb begin
    case (fn)
      FN_CAP_RISE: cap_evt = rise;
      FN_CAP_FALL: cap_evt = fall;
      FN_CAP_BOTH: cap_evt = rise | fall;
      default:     cap_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccc_compare.sv
module ccc_compare
  import ccc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_tick,
  input  logic [CW-1:0] cmp_val,
  input  ccc_fn_e       fn,
  input  logic          apply,
  output logic          match_evt,
  output logic          pin_out
);
  logic pin_q;
  logic pulse_q;

  assign match_evt = cnt_tick & (cnt_val == cmp_val) & ccc_is_compare(fn);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (apply) begin
      pulse_q <= 1'b0;
      case (fn)
        FN_PULSE_HI: pin_q <= 1'b0;
        FN_PULSE_LO: pin_q <= 1'b1;
        FN_OFF:      pin_q <= 1'b0;
        default:     pin_q <= pin_q;
      endcase
    end else if (match_evt) begin
      case (fn)
        FN_TOGGLE:   pin_q <= ~pin_q;
        FN_CLEAR:    pin_q <= 1'b0;
        FN_SET:      pin_q <= 1'b1;
        FN_PULSE_HI: begin pin_q <= 1'b1; pulse_q <= 1'b1; end
        FN_PULSE_LO: begin pin_q <= 1'b0; pulse_q <= 1'b1; end
        default:     pin_q <= pin_q;
      endcase
    end else if (pulse_q && cnt_tick) begin
      pin_q   <= (fn == FN_PULSE_LO);
      pulse_q <= 1'b0;
    end
  end

  assign pin_out = pin_q;
endmodule

// File: rtl/ccc_channel.sv
module ccc_channel
  import ccc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int ACK_LAT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cnt_val,
  input  logic              cnt_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              cap_pin,
  output logic              cmp_pin,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [CW-1:0]     value_rd,
  output logic              flag,
  output logic              irq
);
  ccc_fn_e       fn;
  logic          ien;
  logic          apply;
  logic          match_evt;
  logic          cap_evt;
  logic [CW-1:0] value_q;
  logic          flag_q;
  logic          wr_ctrl;
  logic          wr_val;
  logic          wr_clr;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_val  = wr_en && (wr_addr == ADDR_VAL);
  assign wr_clr  = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];

  ccc_mode_ctl #(.ACK_LAT(ACK_LAT)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (wr_ctrl),
    .wr_word  (wr_data[CTRL_W-1:0]),
    .ctrl_act (ctrl_rd),
    .fn       (fn),
    .ien      (ien),
    .apply    (apply)
  );

  ccc_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .pin_in  (cap_pin),
    .fn      (fn),
    .cap_evt (cap_evt)
  );

  ccc_compare #(.CW(CW)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .cnt_val   (cnt_val),
    .cnt_tick  (cnt_tick),
    .cmp_val   (value_q),
    .fn        (fn),
    .apply     (apply),
    .match_evt (match_evt),
    .pin_out   (cmp_pin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
    end else if (cap_evt) begin
      value_q <= cnt_val;
    end else if (wr_val && !ccc_is_capture(fn)) begin
      value_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (match_evt || cap_evt) begin
      flag_q <= 1'b1;
    end else if (wr_clr) begin
      flag_q <= 1'b0;
    end
  end

  assign value_rd = value_q;
  assign flag     = flag_q;
  assign irq      = flag_q & ien;
endmodule

// File: rtl/ccc_channel_chk.sv
module ccc_channel_chk
  import ccc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int ACK_LAT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [CW-1:0]     cnt_val,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [CW-1:0]     wr_data,
  input logic [CTRL_W-1:0] ctrl_rd,
  input logic [CW-1:0]     value_rd,
  input logic              flag,
  input logic              cmp_pin,
  input logic              match_evt,
  input logic              cap_evt,
  input ccc_fn_e           fn
);
  localparam int SW = $clog2(ACK_LAT + 2) + 1;

  logic [SW-1:0] since_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_wr <= '1;
    end else if (wr_en && wr_addr == ADDR_CTRL) begin
      since_wr <= '0;
    end else if (since_wr != '1) begin
      since_wr <= since_wr + 1'b1;
    end
  end

  p_ack_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd != $past(ctrl_rd)) |-> ($past(since_wr) == SW'(ACK_LAT - 1)));

  p_flag_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(match_evt || cap_evt));

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_addr == ADDR_FLAG && wr_data[0] && !match_evt && !cap_evt) |-> !flag);

  p_capture_value_r6: assert property (@(posedge clk) disable iff (rst)
    $past(cap_evt) |-> (value_rd == $past(cnt_val)));

  p_capture_ro_r7: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_addr == ADDR_VAL && ccc_is_capture(fn) && !cap_evt) |-> (value_rd == $past(value_rd)));

  p_off_pin_r9: assert property (@(posedge clk) disable iff (rst)
    (fn == FN_OFF && $past(fn == FN_OFF)) |-> !cmp_pin);

  p_pulse_start_r5: assert property (@(posedge clk) disable iff (rst)
    (fn == FN_PULSE_HI && $past(fn == FN_PULSE_HI) && $rose(cmp_pin)) |-> $past(match_evt));
endmodule

bind ccc_channel ccc_channel_chk #(
  .CW(CW), .ACK_LAT(ACK_LAT), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_val   (cnt_val),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .ctrl_rd   (ctrl_rd),
  .value_rd  (value_rd),
  .flag      (flag),
  .cmp_pin   (cmp_pin),
  .match_evt (match_evt),
  .cap_evt   (cap_evt),
  .fn        (fn)
);

// File: tb/tb_ccc_channel.sv
module tb_ccc_channel;
  import ccc_pkg::*;

  localparam int CW = 16;
  localparam int ACK_LAT = 2;
  localparam int SYNC_STAGES = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CW-1:0]     cnt_val = '0;
  logic              cnt_tick = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [CW-1:0]     wr_data = '0;
  logic              cap_pin = 1'b0;
  logic              cmp_pin;
  logic [CTRL_W-1:0] ctrl_rd;
  logic [CW-1:0]     value_rd;
  logic              flag;
  logic              irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ccc_channel #(.CW(CW), .ACK_LAT(ACK_LAT), .SYNC_STAGES(SYNC_STAGES)) dut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cap_pin(cap_pin),
    .cmp_pin(cmp_pin), .ctrl_rd(ctrl_rd), .value_rd(value_rd), .flag(flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_mode(input logic [4:0] w);
    wr(ADDR_CTRL, CW'(w));
    repeat (ACK_LAT) @(negedge clk);
  endtask

  task automatic capture_step(input logic newlvl, input logic [CW-1:0] base,
                              input bit expect_cap, input bit clr_first, input string tag);
    logic [CW-1:0] old;
    if (clr_first) wr(ADDR_FLAG, 1);
    old = value_rd;
    cnt_val = base; cap_pin = newlvl;
    @(negedge clk);
    cnt_val = base + 1;
    @(negedge clk);
    chk({tag, " value before sync latency"}, value_rd, old);
    cnt_val = base + 2;
    @(negedge clk);
    chk({tag, " value"}, value_rd, expect_cap ? base + 2 : old);
    if (clr_first) chk({tag, " flag"}, flag, expect_cap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pin", cmp_pin, 0);
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ctrl", ctrl_rd, 0);
    chk("R1 value", value_rd, 0);

    // R2 read-back acknowledge latency
    wr(ADDR_CTRL, CW'(5'b1_01_01));
    for (int k = 0; k < ACK_LAT; k++) begin
      chk("R2 ctrl still old", ctrl_rd, 0);
      @(negedge clk);
    end
    chk("R2 ctrl acknowledged", ctrl_rd, 5'b1_01_01);

    // R3/R4 compare sweep over every select and two match values
    for (int li = 0; li < 4; li++) begin
      for (int vi = 0; vi < 2; vi++) begin
        int v;
        logic ep;
        v = (vi == 0) ? 3 : 9;
        set_mode({1'b0, 2'b01, 2'(li)});
        wr(ADDR_VAL, CW'(v));
        wr(ADDR_FLAG, 1);
        cnt_val = CW'(v); cnt_tick = 1'b0;
        @(negedge clk);
        chk("R3 equal count without tick", flag, 0);
        ep = cmp_pin;
        for (int c = 0; c < 16; c++) begin
          cnt_val = CW'(c); cnt_tick = 1'b1;
          @(negedge clk);
          if (c == v) begin
            case (li)
              1: ep = ~ep;
              2: ep = 1'b0;
              3: ep = 1'b1;
              default: ep = ep;
            endcase
          end
          chk("R4 pin action", cmp_pin, ep);
          chk("R3 flag on match", flag, (c >= v));
        end
        cnt_tick = 1'b0;
        chk("R8 irq masked", irq, 0);
      end
    end

    // R5 pulse modes, counter period 1 and 3 clocks
    for (int pi = 0; pi < 2; pi++) begin
      for (int hl = 0; hl < 2; hl++) begin
        int p;
        logic idle;
        logic actv;
        p = (pi == 0) ? 1 : 3;
        idle = (hl == 1);
        actv = ~idle;
        set_mode({1'b0, 2'b11, (hl == 0) ? 2'b01 : 2'b10});
        @(negedge clk);
        chk("R5 idle level on entry", cmp_pin, idle);
        wr(ADDR_VAL, CW'(5));
        wr(ADDR_FLAG, 1);
        for (int c = 0; c < 10; c++) begin
          for (int j = 0; j < p; j++) begin
            logic e;
            cnt_val = CW'(c); cnt_tick = (j == p - 1);
            @(negedge clk);
            e = ((c == 5 && j == p - 1) || (c == 6 && j < p - 1)) ? actv : idle;
            chk("R5 pulse width", cmp_pin, e);
          end
        end
        cnt_tick = 1'b0;
        chk("R5 flag", flag, 1);
      end
    end

    // R6 capture edges for each select, both directions
    for (int li = 1; li < 4; li++) begin
      set_mode({1'b0, 2'b00, 2'(li)});
      capture_step(1'b1, CW'(16'h100 + li * 16), (li & 1) != 0, 1'b1, "R6 rise");
      capture_step(1'b0, CW'(16'h200 + li * 16), (li & 2) != 0, 1'b1, "R6 fall");
    end

    // R7 overwrite while flag set, value writes ignored in capture mode
    set_mode(5'b1_00_01);
    capture_step(1'b1, CW'(16'h300), 1'b1, 1'b1, "R7 first");
    chk("R8 irq with enable", irq, 1);
    capture_step(1'b0, CW'(16'h310), 1'b0, 1'b0, "R7 fall ignored");
    capture_step(1'b1, CW'(16'h320), 1'b1, 1'b0, "R7 overwrite");
    chk("R7 flag kept", flag, 1);
    wr(ADDR_VAL, CW'(16'h1234));
    @(negedge clk);
    chk("R7 value write ignored", value_rd, 16'h322);

    // R8 flag clear rules
    wr(ADDR_FLAG, 0);
    chk("R8 write 0 no clear", flag, 1);
    wr(ADDR_FLAG, 1);
    chk("R8 write 1 clears", flag, 0);
    chk("R8 irq follows flag", irq, 0);
    cap_pin = 1'b0;
    set_mode(5'b1_01_00);
    wr(ADDR_VAL, CW'(7));
    cnt_val = CW'(7); cnt_tick = 1'b1;
    wr(ADDR_FLAG, 1);
    cnt_tick = 1'b0;
    chk("R8 set beats clear", flag, 1);
    chk("R8 irq", irq, 1);
    wr(ADDR_FLAG, 1);

    // R9 undefined code disables: pin forced low, no match, no capture
    set_mode(5'b0_01_11);
    wr(ADDR_VAL, CW'(2));
    cnt_val = CW'(2); cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
    chk("R4 set before disable", cmp_pin, 1);
    wr(ADDR_FLAG, 1);
    set_mode(5'b0_10_01);
    @(negedge clk);
    chk("R9 pin low when off", cmp_pin, 0);
    for (int c = 0; c < 4; c++) begin
      cnt_val = CW'(c); cnt_tick = 1'b1;
      @(negedge clk);
    end
    cnt_tick = 1'b0;
    chk("R9 no match flag", flag, 0);
    capture_step(1'b1, CW'(16'h400), 1'b0, 1'b1, "R9 no capture");
    set_mode(5'b0_11_11);
    capture_step(1'b0, CW'(16'h500), 1'b0, 1'b1, "R9 mode 11 sel 11");
    set_mode(5'b0_00_00);
    chk("R9 disable read back", ctrl_rd, 0);
    chk("R9 pin", cmp_pin, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule